// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits beside the write path of a byte-wide parallel flash and watches every latched write cycle (address and data). It recognises the keyed unlock sequences that a host writes to two magic addresses. From them it keeps three mode states and raises one request:
- a persistent write-protection flag;
- a product-identification mode;
- a chip-erase request, held until the erase engine reports completion.

All sequences share a two-byte key, so one tracker follows them in parallel and branches on the third and sixth bytes.

Writes that are not part of a command are passed on to the page-load path as a one-cycle strobe with address and data. When protection is on, they are passed on only inside a load window. That window is opened by the three-byte write unlock and closed by the page programmer's done pulse.

In identification mode the block answers reads at offsets 0 and 1 with fixed identification bytes. Two reset inputs separate storage classes:
- the hard reset clears everything, including the protection flag;
- a power-cycle input clears every volatile state and leaves the protection flag as it was.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous `rst` clears `prot_en`, `id_mode`, `erase_req`, `ld_valid` and `id_hit` in the cycle after it is sampled high.
- R2: The common key is data AAh at address 5555h followed by data 55h at address 2AAAh. Only address bits 14..0 take part in the comparison, so 15555h and 12AAAh match as well.
- R3: Key followed by A0h at 5555h sets `prot_en` to 1 and opens the load window. Each later write is then forwarded: `ld_valid` is high for one cycle, in the cycle after the write, carrying its `ld_addr`/`ld_data`. This continues until `load_done` is sampled high.
- R4: Key, 80h at 5555h, key again, then 20h at 5555h clears `prot_en`.
- R5: The same six-byte form ending in 10h raises `erase_req`. It stays high until `erase_done` is sampled, and writes that arrive while it is high are neither forwarded nor decoded.
- R6: The six-byte form ending in 60h sets `id_mode`. In that mode a read at address 0 gives `id_hit`=1 and `id_data`=DAh in the next cycle, and address 1 gives C1h. Any other address, or any read outside the mode, gives `id_hit`=0.
- R7: Key followed by F0h at 5555h clears `id_mode`.
- R8: A write that advances or completes a sequence is never forwarded. A write that does not is forwarded in two cases: when `prot_en` is 0, or when the load window is open. With `prot_en`=1 and the window closed, it is dropped.
- R9: A write that does not match the expected next byte returns the tracker to idle and is handled as a data write. If that write is itself AAh at 5555h, it counts as the first key byte instead.
- R10: `pwr_cycle` clears `id_mode`, `erase_req`, the load window and the sequence state, and leaves `prot_en` unchanged.
- R11: While the load window is open, every write is forwarded as data and none is decoded as a command, including AAh at 5555h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of all state, including the persistent protection flag |
| pwr_cycle | input | 1 | Power-transition reset; clears volatile state only |
| wr_valid | input | 1 | One latched write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_valid | input | 1 | One read cycle this clock |
| rd_addr | input | ADDR_W | Read address |
| load_done | input | 1 | Page programmer has taken the loaded page; closes the load window |
| erase_done | input | 1 | Erase engine finished |
| prot_en | output | 1 | Software write protection active |
| id_mode | output | 1 | Identification mode active |
| erase_req | output | 1 | Chip-erase request, held until done |
| ld_valid | output | 1 | Forwarded data write strobe |
| ld_addr | output | ADDR_W | Forwarded write address |
| ld_data | output | 8 | Forwarded write data |
| id_hit | output | 1 | Read answered from the identification bytes |
| id_data | output | 8 | Identification byte, zero when not hit |

## Verification
The assertions assume a handshake discipline on the inputs:
- `erase_done` arrives only while `erase_req` is high.
- `load_done` is never pulsed in the same cycle as a write unlock.
- `rst` is held for the first clock.

The stimulus drives every input at the falling edge and pulses each done signal alone, after the matching request is seen. This keeps every run inside that envelope. Command writes and data writes are interleaved so that the tracker meets these cases:
- sequences restarted mid-stream;
- high address bits set on key bytes;
- key bytes arriving inside an open load window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int KEY_W  = 15;

  localparam logic [KEY_W-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_LO = 15'h2AAA;

  localparam logic [BYTE_W-1:0] KEY_D1       = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_D2       = 8'h55;
  localparam logic [BYTE_W-1:0] OP_WR_UNLOCK = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_EXTEND    = 8'h80;
  localparam logic [BYTE_W-1:0] OP_ID_EXIT   = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_PROT_OFF  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_ERASE     = 8'h10;
  localparam logic [BYTE_W-1:0] OP_ID_ENTER  = 8'h60;

  // Position inside the keyed stream: K* = short key, X* = extended form
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_K1   = 3'd1,
    SQ_K2   = 3'd2,
    SQ_X3   = 3'd3,
    SQ_X4   = 3'd4,
    SQ_X5   = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic consumed;
    logic prot_on;
    logic prot_off;
    logic erase;
    logic id_enter;
    logic id_exit;
  } cmd_evt_t;

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              step_en,
  input  logic [CMP_W-1:0]  key_addr,
  input  logic [BYTE_W-1:0] key_data,
  output cmd_evt_t          evt,
  output seq_state_t        state
);

  localparam logic [CMP_W-1:0] A_HI = CMP_W'(KEY_ADDR_HI);
  localparam logic [CMP_W-1:0] A_LO = CMP_W'(KEY_ADDR_LO);

  seq_state_t nxt;
  logic       at_hi, at_lo, is_start, is_second, matched;

  always_comb begin
    at_hi     = (key_addr == A_HI);
    at_lo     = (key_addr == A_LO);
    is_start  = at_hi && (key_data == KEY_D1);
    is_second = at_lo && (key_data == KEY_D2);
  end

  always_comb begin
    nxt     = state;
    evt     = '0;
    matched = 1'b0;
    if (step_en) begin
      nxt = SQ_IDLE;
      case (state)
        SQ_IDLE: if (is_start)  begin nxt = SQ_K1; matched = 1'b1; end
        SQ_K1:   if (is_second) begin nxt = SQ_K2; matched = 1'b1; end
        SQ_K2: begin
          if (at_hi) begin
            case (key_data)
              OP_WR_UNLOCK: begin matched = 1'b1; evt.prot_on = 1'b1; end
              OP_ID_EXIT:   begin matched = 1'b1; evt.id_exit = 1'b1; end
              OP_EXTEND:    begin matched = 1'b1; nxt = SQ_X3; end
              default: ;
            endcase
          end
        end
        SQ_X3:   if (is_start)  begin nxt = SQ_X4; matched = 1'b1; end
        SQ_X4:   if (is_second) begin nxt = SQ_X5; matched = 1'b1; end
        SQ_X5: begin
          if (at_hi) begin
            case (key_data)
              OP_PROT_OFF: begin matched = 1'b1; evt.prot_off = 1'b1; end
              OP_ERASE:    begin matched = 1'b1; evt.erase    = 1'b1; end
              OP_ID_ENTER: begin matched = 1'b1; evt.id_enter = 1'b1; end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
      // An unexpected byte drops to idle; a fresh first key byte restarts
      if (!matched && is_start) begin
        nxt     = SQ_K1;
        matched = 1'b1;
      end
      evt.consumed = matched;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) state <= SQ_IDLE;
    else              state <= nxt;
  end

endmodule

// File: rtl/flash_mode_regs.sv
module flash_mode_regs
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pwr_cycle,
  input  cmd_evt_t evt,
  input  logic     load_done,
  input  logic     erase_done,
  output logic     prot_en,
  output logic     id_mode,
  output logic     erase_req,
  output logic     load_win
);

  // Non-volatile flag: only the hard reset touches it
  always_ff @(posedge clk) begin
    if (rst)               prot_en <= 1'b0;
    else if (evt.prot_on)  prot_en <= 1'b1;
    else if (evt.prot_off) prot_en <= 1'b0;
  end

  // Volatile state: cleared by either reset
  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      id_mode   <= 1'b0;
      erase_req <= 1'b0;
      load_win  <= 1'b0;
    end else begin
      if (evt.id_enter)     id_mode <= 1'b1;
      else if (evt.id_exit) id_mode <= 1'b0;

      if (evt.erase)        erase_req <= 1'b1;
      else if (erase_done)  erase_req <= 1'b0;

      if (evt.prot_on)      load_win <= 1'b1;
      else if (load_done)   load_win <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import flash_cmd_pkg::*;
#(
  parameter int                      ADDR_W   = 17,
  parameter int                      N_ID     = 2,
  parameter logic [N_ID*BYTE_W-1:0]  ID_TABLE = {8'hC1, 8'hDA}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              id_mode,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_hit,
  output logic [BYTE_W-1:0] id_data
);

  logic [N_ID-1:0] sel;
  logic [BYTE_W-1:0] pick;

  generate
    for (genvar i = 0; i < N_ID; i++) begin : g_entry
      assign sel[i] = (rd_addr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_ID; i++) begin
      if (sel[i]) pick = ID_TABLE[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      id_hit  <= 1'b0;
      id_data <= '0;
    end else if (rd_valid && id_mode && (|sel)) begin
      id_hit  <= 1'b1;
      id_data <= pick;
    end else begin
      id_hit  <= 1'b0;
      id_data <= '0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              load_done,
  input  logic              erase_done,
  output logic              prot_en,
  output logic              id_mode,
  output logic              erase_req,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data,
  output logic              id_hit,
  output logic [7:0]        id_data
);

  cmd_evt_t   evt;
  seq_state_t seq_state;
  logic       load_win;
  logic       wr_live, step_en, fwd;

  // Writes are dead during erase or a power transition
  assign wr_live = wr_valid && !pwr_cycle && !erase_req;
  // An open load window takes every write as data
  assign step_en = wr_live && !load_win;
  assign fwd     = wr_live && (load_win || (!evt.consumed && !prot_en));

  flash_seq_tracker #(.CMP_W(CMP_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .flush    (pwr_cycle),
    .step_en  (step_en),
    .key_addr (wr_addr[CMP_W-1:0]),
    .key_data (wr_data),
    .evt      (evt),
    .state    (seq_state)
  );

  flash_mode_regs u_modes (
    .clk        (clk),
    .rst        (rst),
    .pwr_cycle  (pwr_cycle),
    .evt        (evt),
    .load_done  (load_done),
    .erase_done (erase_done),
    .prot_en    (prot_en),
    .id_mode    (id_mode),
    .erase_req  (erase_req),
    .load_win   (load_win)
  );

  flash_id_responder #(.ADDR_W(ADDR_W)) u_id (
    .clk       (clk),
    .rst       (rst),
    .pwr_cycle (pwr_cycle),
    .id_mode   (id_mode),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .id_hit    (id_hit),
    .id_data   (id_data)
  );

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      ld_valid <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= fwd;
      if (fwd) begin
        ld_addr <= wr_addr;
        ld_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_cycle,
  input logic       wr_valid,
  input logic       erase_done,
  input logic       prot_en,
  input logic       id_mode,
  input logic       erase_req,
  input logic       ld_valid,
  input logic       id_hit,
  input logic [7:0] id_data,
  input logic       load_win
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!prot_en && !id_mode && !erase_req && !ld_valid && !id_hit));

  assert_prot_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_en) |-> ($past(wr_valid) && load_win));

  assert_erase_held_R5: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_done && !pwr_cycle) |=> erase_req);

  assert_erase_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !ld_valid);

  assert_id_value_R6: assert property (@(posedge clk) disable iff (rst)
    id_hit |-> ((id_data == 8'hDA || id_data == 8'hC1) && $past(id_mode)));

  assert_prot_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && prot_en && !load_win) |=> !ld_valid);

  assert_pwr_keeps_prot_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle |=> ((prot_en == $past(prot_en)) && !id_mode && !erase_req && !load_win));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_cycle  (pwr_cycle),
  .wr_valid   (wr_valid),
  .erase_done (erase_done),
  .prot_en    (prot_en),
  .id_mode    (id_mode),
  .erase_req  (erase_req),
  .ld_valid   (ld_valid),
  .id_hit     (id_hit),
  .id_data    (id_data),
  .load_win   (load_win)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_cycle = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          load_done = 1'b0;
  logic          erase_done = 1'b0;
  logic          prot_en, id_mode, erase_req, ld_valid, id_hit;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data, id_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .load_done(load_done), .erase_done(erase_done),
    .prot_en(prot_en), .id_mode(id_mode), .erase_req(erase_req),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .id_hit(id_hit), .id_data(id_data)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int        m_step;
  bit        m_prot, m_id, m_erase, m_win, m_ldv, m_hit;
  bit [AW-1:0] m_lda;
  bit [7:0]  m_ldd, m_idd;

  function automatic bit key_a(input bit [AW-1:0] a, input bit [7:0] d);
    return (a[14:0] == 15'h5555) && (d == 8'hAA);
  endfunction
  function automatic bit key_b(input bit [AW-1:0] a, input bit [7:0] d);
    return (a[14:0] == 15'h2AAA) && (d == 8'h55);
  endfunction

  always @(posedge clk) begin
    bit cmd;
    int nstep;
    bit hi;
    if (rst) begin
      m_step <= 0; m_prot <= 0; m_id <= 0; m_erase <= 0; m_win <= 0;
      m_ldv <= 0; m_hit <= 0; m_idd <= 0;
    end else if (pwr_cycle) begin
      m_step <= 0; m_id <= 0; m_erase <= 0; m_win <= 0;
      m_ldv <= 0; m_hit <= 0; m_idd <= 0;
    end else begin
      m_ldv <= 0;
      if (m_erase && erase_done) m_erase <= 0;
      if (m_win && load_done) m_win <= 0;
      if (wr_valid && !m_erase) begin
        if (m_win) begin
          m_ldv <= 1; m_lda <= wr_addr; m_ldd <= wr_data;
        end else begin
          cmd = 0; nstep = 0;
          hi = (wr_addr[14:0] == 15'h5555);
          if (m_step == 0 && key_a(wr_addr, wr_data)) begin cmd = 1; nstep = 1; end
          else if (m_step == 1 && key_b(wr_addr, wr_data)) begin cmd = 1; nstep = 2; end
          else if (m_step == 3 && key_a(wr_addr, wr_data)) begin cmd = 1; nstep = 4; end
          else if (m_step == 4 && key_b(wr_addr, wr_data)) begin cmd = 1; nstep = 5; end
          else if (m_step == 2 && hi && wr_data == 8'hA0) begin cmd = 1; m_prot <= 1; m_win <= 1; end
          else if (m_step == 2 && hi && wr_data == 8'hF0) begin cmd = 1; m_id <= 0; end
          else if (m_step == 2 && hi && wr_data == 8'h80) begin cmd = 1; nstep = 3; end
          else if (m_step == 5 && hi && wr_data == 8'h20) begin cmd = 1; m_prot <= 0; end
          else if (m_step == 5 && hi && wr_data == 8'h10) begin cmd = 1; m_erase <= 1; end
          else if (m_step == 5 && hi && wr_data == 8'h60) begin cmd = 1; m_id <= 1; end
          else if (key_a(wr_addr, wr_data)) begin cmd = 1; nstep = 1; end
          m_step <= nstep;
          if (!cmd && !m_prot) begin
            m_ldv <= 1; m_lda <= wr_addr; m_ldd <= wr_data;
          end
        end
      end
      m_hit <= rd_valid && m_id && (rd_addr == 0 || rd_addr == 1);
      m_idd <= (rd_valid && m_id && rd_addr == 0) ? 8'hDA :
               (rd_valid && m_id && rd_addr == 1) ? 8'hC1 : 8'h00;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3/R4 prot_en model", prot_en, m_prot);
      chk("R6/R7 id_mode model", id_mode, m_id);
      chk("R5 erase_req model", erase_req, m_erase);
      chk("R8 ld_valid model", ld_valid, m_ldv);
      if (m_ldv) begin
        chk("R3 ld_addr model", ld_addr, m_lda);
        chk("R3 ld_data model", ld_data, m_ldd);
      end
      chk("R6 id_hit model", id_hit, m_hit);
      chk("R6 id_data model", id_data, m_idd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic pulse_load_done();
    @(negedge clk); load_done = 1;
    @(negedge clk); load_done = 0;
  endtask

  task automatic key();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic six(input logic [7:0] op);
    key();
    wr(17'h05555, 8'h80);
    key();
    wr(17'h05555, op);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 prot_en", prot_en, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 erase_req", erase_req, 0);
    chk("R1 ld_valid", ld_valid, 0);

    // R8 unprotected data write forwarded
    wr(17'h00123, 8'h5A);
    chk("R8 fwd valid", ld_valid, 1);
    chk("R8 fwd data", ld_data, 8'h5A);
    // R8 command byte not forwarded; R9 mismatch forwarded
    wr(17'h05555, 8'hAA);
    chk("R8 key byte dropped", ld_valid, 0);
    wr(17'h00200, 8'h11);
    chk("R9 mismatch fwd", ld_valid, 1);

    // R2 high address bits ignored; R3 unlock
    wr(17'h15555, 8'hAA);
    wr(17'h12AAA, 8'h55);
    wr(17'h15555, 8'hA0);
    chk("R2 R3 prot set", prot_en, 1);
    wr(17'h00400, 8'h77);
    chk("R3 window fwd", ld_valid, 1);
    chk("R3 window addr", ld_addr, 17'h00400);
    // R11 key byte inside window is data
    wr(17'h05555, 8'hAA);
    chk("R11 key as data", ld_valid, 1);
    chk("R11 key data", ld_data, 8'hAA);
    pulse_load_done();

    // R8 protected write dropped
    wr(17'h00500, 8'h22);
    chk("R8 protected drop", ld_valid, 0);

    // R9 restart on repeated first byte
    wr(17'h05555, 8'hAA);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'hA0);
    wr(17'h00600, 8'h33);
    chk("R9 restart unlock", ld_valid, 1);
    pulse_load_done();

    // R6 identification
    six(8'h60);
    chk("R6 id_mode", id_mode, 1);
    rd(17'h00000);
    chk("R6 hit0", id_hit, 1);
    chk("R6 byte0", id_data, 8'hDA);
    rd(17'h00001);
    chk("R6 byte1", id_data, 8'hC1);
    rd(17'h00002);
    chk("R6 other addr", id_hit, 0);

    // R10 power cycle
    @(negedge clk); pwr_cycle = 1;
    @(negedge clk); pwr_cycle = 0;
    chk("R10 id cleared", id_mode, 0);
    chk("R10 prot kept", prot_en, 1);

    // R7 exit
    six(8'h60);
    key();
    wr(17'h05555, 8'hF0);
    chk("R7 id exit", id_mode, 0);
    rd(17'h00000);
    chk("R7 no hit", id_hit, 0);

    // R5 erase
    six(8'h10);
    chk("R5 erase req", erase_req, 1);
    key();
    wr(17'h05555, 8'hA0);
    chk("R5 writes ignored", ld_valid, 0);
    repeat (5) @(negedge clk);
    chk("R5 held", erase_req, 1);
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
    chk("R5 released", erase_req, 0);
    wr(17'h00700, 8'h44);
    chk("R5 no window from ignored unlock", ld_valid, 0);

    // R4 disable
    six(8'h20);
    chk("R4 prot cleared", prot_en, 0);
    wr(17'h00800, 8'h55);
    chk("R4 unprotected fwd", ld_valid, 1);

    // R1 hard reset clears persistent flag
    key();
    wr(17'h05555, 8'hA0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 prot after rst", prot_en, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule